// File: doc/BRIEF.md
# Auto-Reload Timer Counter

This block is the counting core of a general-purpose timer. A prescaler outside the block supplies a count tick. The core advances a 16-bit counter on each tick while it is enabled. The counter follows one of five patterns:

- ramp up to a reload limit;
- ramp down from that limit;
- one of three symmetric up/down patterns that bounce between zero and the limit.

Each wrap at the top or bottom can raise an update event, which is a one-cycle pulse. The same event can set a sticky interrupt flag. Software can also force an update event. A forced update reinitialises the counter.

The reload limit is written through a buffer register. A control bit decides when a written limit takes effect: at once, or only at the next update event. In the symmetric patterns the direction is owned by the hardware and reported on an output. A direction strobe tells downstream compare logic in which counting direction its flags may be raised.

Top module: `reload_timer_core`

## Requirements
- R1: With `align_i`=00 and direction 0 (up), each counting step adds one. From a value at or above the active limit, a step goes to 0 and produces an update event.
- R2: With `align_i`=00 and direction 1 (down), each step subtracts one. A step from 0 loads the active limit and produces an update event.
- R3: With `align_i` not 00, the counter rises from 0 to the limit. A step at the limit moves it to limit-1, makes `dir_o`=1 and produces an event. It then falls to 0. A step at 0 moves it to 1, makes `dir_o`=0 and produces an event.
- R4: With `align_i` not 00, `dir_sw_i` is ignored and `dir_o` shows the hardware direction. With `align_i`=00, `dir_o` takes `dir_sw_i` one cycle later.
- R5: `cmp_qual_o` is 1 for `align_i`=00 and 11. It equals `dir_o` for 01 and equals the inverse of `dir_o` for 10.
- R6: With `preload_en_i`=0, a limit write is active from the next cycle. With `preload_en_i`=1, the written limit becomes active only at the next update event.
- R7: While `upd_block_i`=1, a wrap produces no update event and does not set the flag. The counter still wraps.
- R8: A `force_upd_i` pulse gives an `upd_evt_o` pulse one cycle later. It also reinitialises the counter: to the written limit when `align_i`=00 and down, to 0 otherwise. In the symmetric patterns it also sets the direction to up.
- R9: With `flag_src_i`=1, only wrap events set `upd_flag_o`. With `flag_src_i`=0, a forced update sets it as well.
- R10: `upd_flag_o` stays set until a `flag_clr_i` pulse clears it.
- R11: Counting uses `run_en_i` delayed by one clock. A step happens on an edge only if `run_en_i` was high one cycle before that edge.
- R12: An active limit of 0 holds the counter at 0 and produces no wrap events.
- R13: A `cnt_wr_i` pulse loads `cnt_wdata_i` into the counter on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Count tick from the prescaler |
| run_en_i | input | 1 | Software count enable |
| dir_sw_i | input | 1 | Software direction, 0 up, 1 down |
| align_i | input | 2 | Pattern: 00 one-way, 01/10/11 symmetric |
| upd_block_i | input | 1 | Suppress wrap update events |
| flag_src_i | input | 1 | Flag only on wraps when 1 |
| preload_en_i | input | 1 | Buffer limit writes until update |
| force_upd_i | input | 1 | Software update pulse |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 16 | Counter write value |
| top_wr_i | input | 1 | Limit write strobe |
| top_wdata_i | input | 16 | Limit write value |
| flag_clr_i | input | 1 | Clear update flag |
| count_o | output | 16 | Counter value |
| dir_o | output | 1 | Current direction |
| upd_evt_o | output | 1 | Update event pulse |
| upd_flag_o | output | 1 | Sticky update flag |
| cmp_qual_o | output | 1 | Compare-flag direction qualifier |

## Verification
The count enable passes through one register before it gates the counter. A run that holds `run_en_i` high across N edges therefore makes exactly N steps, on the second through the (N+1)-th edge. The bench counts windows that way and reads `count_o` only after the last step has settled. The event pulse and the flag appear one edge after the edge that wraps or forces. So the bench samples pulses at every falling edge through the run and for three cycles after it. Forced-update results, write results and direction results are checked at the falling edge that follows the edge that consumed the stimulus.

// File: rtl/reload_timer_core.sv
module reload_timer_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         run_en_i,
  input  logic         dir_sw_i,
  input  logic [1:0]   align_i,
  input  logic         upd_block_i,
  input  logic         flag_src_i,
  input  logic         preload_en_i,
  input  logic         force_upd_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         top_wr_i,
  input  logic [W-1:0] top_wdata_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] count_o,
  output logic         dir_o,
  output logic         upd_evt_o,
  output logic         upd_flag_o,
  output logic         cmp_qual_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, top_pre, top_act, cnt_step;
  logic         dir_q, run_q, dir_step, wrap;

  wire step      = run_q && tick_i;
  wire one_way   = (align_i == 2'b00);
  wire zero_top  = (top_act == '0);
  wire at_top    = (cnt_q >= top_act);
  wire at_bot    = (cnt_q == '0);
  wire wrap_ev   = wrap && !force_upd_i && !cnt_wr_i;
  wire wrap_upd  = wrap_ev && !upd_block_i;
  wire upd_set   = wrap_upd || force_upd_i;
  wire force_top = one_way && dir_q;

  assign count_o    = cnt_q;
  assign dir_o      = dir_q;
  assign cmp_qual_o = (align_i == 2'b01) ? dir_q :
                      (align_i == 2'b10) ? !dir_q : 1'b1;

  always_comb begin
    cnt_step = cnt_q;
    dir_step = dir_q;
    wrap     = 1'b0;
    if (zero_top) begin
      cnt_step = '0;
    end else if (!dir_q) begin
      wrap = step && at_top;
      if (at_top) begin
        cnt_step = one_way ? '0 : top_act - ONE;
        dir_step = !one_way;
      end else begin
        cnt_step = cnt_q + ONE;
      end
    end else begin
      wrap = step && at_bot;
      if (at_bot) begin
        cnt_step = one_way ? top_act : ONE;
        dir_step = one_way;
      end else begin
        cnt_step = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (force_upd_i) begin
      cnt_q <= force_top ? top_pre : '0;
      dir_q <= one_way ? dir_sw_i : 1'b0;
    end else if (cnt_wr_i) begin
      cnt_q <= cnt_wdata_i;
      dir_q <= one_way ? dir_sw_i : dir_q;
    end else if (step) begin
      cnt_q <= cnt_step;
      dir_q <= one_way ? dir_sw_i : dir_step;
    end else begin
      dir_q <= one_way ? dir_sw_i : dir_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_pre <= '1;
      top_act <= '1;
    end else begin
      if (top_wr_i) top_pre <= top_wdata_i;
      if (top_wr_i && !preload_en_i) top_act <= top_wdata_i;
      else if (preload_en_i && upd_set) top_act <= top_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_evt_o  <= 1'b0;
      upd_flag_o <= 1'b0;
    end else begin
      upd_evt_o <= upd_set;
      if (wrap_upd || (force_upd_i && !flag_src_i)) upd_flag_o <= 1'b1;
      else if (flag_clr_i)                          upd_flag_o <= 1'b0;
    end
  end

  // R7
  blocked_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_block_i && !force_upd_i) |=> !upd_evt_o);

  // R8
  force_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd_i |=> upd_evt_o);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_flag_o && !flag_clr_i) |=> upd_flag_o);

  // R11
  run_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en_i ##1 (!force_upd_i && !cnt_wr_i)) |=> $stable(cnt_q));

  // R12
  zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_top && at_bot && !force_upd_i && !cnt_wr_i) |=> (cnt_q == '0));

  // R4
  hw_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_way && !force_upd_i && !tick_i) |=> $stable(dir_q));

endmodule

// File: tb/reload_timer_core_tb.sv
module reload_timer_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1, run_en_i = 1'b0, dir_sw_i = 1'b0;
  logic [1:0] align_i = 2'b00;
  logic upd_block_i = 1'b0, flag_src_i = 1'b0, preload_en_i = 1'b0;
  logic force_upd_i = 1'b0, cnt_wr_i = 1'b0, top_wr_i = 1'b0, flag_clr_i = 1'b0;
  logic [15:0] cnt_wdata_i = '0, top_wdata_i = '0;
  logic [15:0] count_o;
  logic dir_o, upd_evt_o, upd_flag_o, cmp_qual_o;
  int checks = 0, failures = 0, ev = 0;

  always #4 clk = ~clk;

  reload_timer_core #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_en_i(run_en_i),
    .dir_sw_i(dir_sw_i), .align_i(align_i), .upd_block_i(upd_block_i),
    .flag_src_i(flag_src_i), .preload_en_i(preload_en_i),
    .force_upd_i(force_upd_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .top_wr_i(top_wr_i), .top_wdata_i(top_wdata_i), .flag_clr_i(flag_clr_i),
    .count_o(count_o), .dir_o(dir_o), .upd_evt_o(upd_evt_o),
    .upd_flag_o(upd_flag_o), .cmp_qual_o(cmp_qual_o));

  // align, dir, top, steps, expected count, expected events, expected dir
  localparam logic [47:0] VEC [12] = '{
    {2'b00, 1'b0, 16'd5, 8'd3,  16'd3, 4'd0, 1'b0},
    {2'b00, 1'b0, 16'd5, 8'd6,  16'd0, 4'd1, 1'b0},
    {2'b00, 1'b0, 16'd5, 8'd14, 16'd2, 4'd2, 1'b0},
    {2'b00, 1'b1, 16'd4, 8'd4,  16'd0, 4'd0, 1'b1},
    {2'b00, 1'b1, 16'd4, 8'd5,  16'd4, 4'd1, 1'b1},
    {2'b00, 1'b1, 16'd4, 8'd12, 16'd2, 4'd2, 1'b1},
    {2'b11, 1'b0, 16'd3, 8'd4,  16'd2, 4'd1, 1'b1},
    {2'b11, 1'b0, 16'd3, 8'd7,  16'd1, 4'd2, 1'b0},
    {2'b11, 1'b0, 16'd3, 8'd10, 16'd2, 4'd3, 1'b1},
    {2'b01, 1'b0, 16'd1, 8'd3,  16'd1, 4'd2, 1'b0},
    {2'b00, 1'b0, 16'd0, 8'd5,  16'd0, 4'd0, 1'b0},
    {2'b10, 1'b0, 16'd6, 8'd9,  16'd3, 4'd1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] al, input logic d, input logic [15:0] top);
    @(negedge clk);
    align_i = al; dir_sw_i = d; preload_en_i = 1'b0; upd_block_i = 1'b0;
    flag_src_i = 1'b0; top_wr_i = 1'b1; top_wdata_i = top;
    @(negedge clk); top_wr_i = 1'b0;
    @(negedge clk); force_upd_i = 1'b1;
    @(negedge clk); force_upd_i = 1'b0; flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
  endtask

  task automatic run(input int n);
    ev = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ev += int'(upd_evt_o); run_en_i = 1'b1;
    end
    @(negedge clk); ev += int'(upd_evt_o); run_en_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ev += int'(upd_evt_o);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset count", int'(count_o), 0);
    chk("reset flag R10", int'(upd_flag_o), 0);
    chk("reset evt", int'(upd_evt_o), 0);
    chk("reset R5 qual", int'(cmp_qual_o), 1);

    // R13 counter write
    cnt_wr_i = 1'b1; cnt_wdata_i = 16'd7;
    @(negedge clk); cnt_wr_i = 1'b0;
    chk("R13 write", int'(count_o), 7);

    // R11 enable delay
    run_en_i = 1'b1;
    @(negedge clk); run_en_i = 1'b0;
    chk("R11 no step yet", int'(count_o), 7);
    @(negedge clk);
    chk("R11 one step", int'(count_o), 8);
    @(negedge clk);
    chk("R11 stopped", int'(count_o), 8);

    // table of patterns: R1 R2 R3 R12
    for (int k = 0; k < 12; k++) begin
      setup(VEC[k][47:46], VEC[k][45], VEC[k][44:29]);
      run(int'(VEC[k][28:21]));
      chk($sformatf("R1/R2/R3/R12 vec%0d count", k), int'(count_o), int'(VEC[k][20:5]));
      chk($sformatf("R1/R2/R3/R12 vec%0d events", k), ev, int'(VEC[k][4:1]));
      chk($sformatf("R4 vec%0d dir", k), int'(dir_o), int'(VEC[k][0]));
      chk($sformatf("R10 vec%0d flag", k), int'(upd_flag_o), int'(VEC[k][4:1] != 0));
    end

    // R8 forced update reinit
    setup(2'b00, 1'b0, 16'd9);
    cnt_wr_i = 1'b1; cnt_wdata_i = 16'd4;
    @(negedge clk); cnt_wr_i = 1'b0; force_upd_i = 1'b1;
    @(negedge clk); force_upd_i = 1'b0;
    chk("R8 up reinit", int'(count_o), 0);
    chk("R8 pulse", int'(upd_evt_o), 1);
    @(negedge clk);
    chk("R8 pulse ends", int'(upd_evt_o), 0);
    dir_sw_i = 1'b1;
    @(negedge clk); force_upd_i = 1'b1;
    @(negedge clk); force_upd_i = 1'b0;
    chk("R8 down reinit", int'(count_o), 9);

    // R9 flag source
    flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0; flag_src_i = 1'b1; force_upd_i = 1'b1;
    @(negedge clk); force_upd_i = 1'b0;
    chk("R9 evt with src=1", int'(upd_evt_o), 1);
    chk("R9 no flag src=1", int'(upd_flag_o), 0);
    flag_src_i = 1'b0; force_upd_i = 1'b1;
    @(negedge clk); force_upd_i = 1'b0;
    chk("R9 flag src=0", int'(upd_flag_o), 1);
    repeat (3) @(negedge clk);
    chk("R10 flag sticky", int'(upd_flag_o), 1);
    flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
    chk("R10 flag cleared", int'(upd_flag_o), 0);

    // R7 update disable
    setup(2'b00, 1'b0, 16'd3);
    upd_block_i = 1'b1;
    run(8);
    chk("R7 count wraps", int'(count_o), 0);
    chk("R7 no events", ev, 0);
    chk("R7 no flag", int'(upd_flag_o), 0);
    run(1);
    chk("R7 wrapped then stepped", int'(count_o), 1);
    upd_block_i = 1'b0;

    // R6 preload
    setup(2'b00, 1'b0, 16'd5);
    preload_en_i = 1'b1; top_wr_i = 1'b1; top_wdata_i = 16'd2;
    @(negedge clk); top_wr_i = 1'b0;
    run(4);
    chk("R6 old limit held", int'(count_o), 4);
    run(2);
    chk("R6 wrap at old limit", int'(count_o), 0);
    chk("R6 one event", ev, 1);
    run(4);
    chk("R6 new limit active", int'(count_o), 1);
    preload_en_i = 1'b0; top_wr_i = 1'b1; top_wdata_i = 16'd1;
    @(negedge clk); top_wr_i = 1'b0;
    run(1);
    chk("R6 immediate limit", int'(count_o), 0);
    chk("R6 immediate wrap event", ev, 1);

    // R4 R5 hardware direction and qualifier
    setup(2'b11, 1'b0, 16'd3);
    dir_sw_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 sw dir ignored", int'(dir_o), 0);
    chk("R5 mode11 up", int'(cmp_qual_o), 1);
    align_i = 2'b01;
    #1 chk("R5 mode01 up", int'(cmp_qual_o), 0);
    align_i = 2'b10;
    #1 chk("R5 mode10 up", int'(cmp_qual_o), 1);
    align_i = 2'b11;
    run(4);
    chk("R3 descending", int'(count_o), 2);
    dir_sw_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 hw dir down", int'(dir_o), 1);
    align_i = 2'b01;
    #1 chk("R5 mode01 down", int'(cmp_qual_o), 1);
    align_i = 2'b10;
    #1 chk("R5 mode10 down", int'(cmp_qual_o), 0);
    align_i = 2'b00;
    @(negedge clk);
    chk("R4 one-way follows sw", int'(dir_o), 0);
    chk("R5 mode00", int'(cmp_qual_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule